// File: doc/BRIEF.md
# Thermostat Alert with Consecutive-Fault Filter

This block watches a stream of signed temperature results and decides when a thermal alert should be raised. Each time a conversion finishes, the result is compared against a programmable upper limit and a programmable lower limit. A fault is counted only when the required number of consecutive results have crossed the limit being watched. The number required is 1, 2, 4 or 6 and is chosen by a 2-bit setting.

The alert output works in one of two styles. In comparator style the output is a thermostat with hysteresis. It turns on at or above the upper limit and turns off only once results fall below the lower limit. In interrupt style the output latches on a crossing and stays set until software acknowledges it. Any register read, a won alert-response, or entry into shutdown counts as an acknowledgement. After each acknowledgement the block swaps which limit it watches.

Two further outputs feed the host interface. One is a status bit that always mirrors the comparator-style state. The other is a cause bit for the alert-response reply, which reports whether the upper or the lower limit triggered the alert. Both of these outputs and the alert pin follow a polarity setting.

Top module: `thermo_alert`

## Requirements
- R1: Field fq_sel_i sets the run length needed to count a fault: 2'b00 needs 1 conversion, 2'b01 needs 2, 2'b10 needs 4 and 2'b11 needs 6.
- R2: In comparator mode (int_mode_i=0), the alert becomes active in the cycle after the conversion that completes the required run of results greater than or equal to hi_lim_i.
- R3: In comparator mode, an active alert becomes inactive only after the required run of results strictly below lo_lim_i. Results between the two limits hold the current state.
- R4: A conversion that fails the condition being watched restarts the run count from zero.
- R5: In interrupt mode (int_mode_i=1), the alert latches after the required run and stays active while conversions continue. It is cleared in the cycle after reg_rd_i, ares_won_i or shutdown_i. While int_mode_i=0, the interrupt tracker rests inactive and watches the upper limit.
- R6: After each interrupt-mode clear, the watched condition toggles. The next activation needs the run below lo_lim_i, and the clear after that re-arms the upper-limit check.
- R7: With pol_i=0 the alert pin is low when active. With pol_i=1 it is high when active.
- R8: status_o reflects the comparator-style state in either mode. With pol_i=0 it is 1 with no fault and 0 with a fault, and pol_i=1 inverts it.
- R9: With pol_i=0, cause_o is 0 when the alert came from the upper limit and 1 when it came from the lower limit, and pol_i=1 inverts it. In comparator mode the cause is the upper limit.
- R10: With ext_mode_i=0, results and limits are compared as 12-bit two's complement values taken from bits [11:0]. With ext_mode_i=1, all 13 bits are compared as two's complement.
- R11: Any change of int_mode_i or fq_sel_i empties both run counters at the next clock edge.
- R12: After reset the alert is inactive, the comparator state reports no fault and both run counters are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_done_i | input | 1 | One-cycle strobe: a new result is valid |
| temp_i | input | 13 | Conversion result, two's complement |
| hi_lim_i | input | 13 | Upper limit |
| lo_lim_i | input | 13 | Lower limit |
| ext_mode_i | input | 1 | 1 selects 13-bit comparison, 0 selects 12-bit |
| int_mode_i | input | 1 | 0 selects comparator style, 1 selects interrupt style |
| pol_i | input | 1 | Output polarity |
| fq_sel_i | input | 2 | Consecutive-fault setting |
| reg_rd_i | input | 1 | Strobe: a register was read |
| ares_won_i | input | 1 | Strobe: the alert-response reply was won |
| shutdown_i | input | 1 | Strobe: entry into shutdown |
| alert_o | output | 1 | Alert pin level |
| status_o | output | 1 | Read-only comparator status bit |
| cause_o | output | 1 | Cause bit for the alert-response reply |

## Verification
Several properties are checked on every cycle:
- The comparator state only moves on a conversion strobe.
- In comparator mode the alert pin and the status bit agree.
- An interrupt latch rises only after a conversion.
- An interrupt latch always drops after an acknowledgement.
- Run counters never pass five.

Some behaviour can only be shown by the bench scenarios. These are the exact run lengths for each fault setting, the restart of a run on a miss, and the emptying of counters when settings change. The scenarios also cover the high/low alternation across interrupt clears, the 12-bit versus 13-bit sign interpretation of limits, and the polarity of all three outputs.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam int unsigned TEMP_W = 13;
  localparam int unsigned FQ_MAX = 6;
  localparam int unsigned CNT_W  = $clog2(FQ_MAX + 1);

  function automatic logic [CNT_W-1:0] fault_need(input logic [1:0] sel);
    case (sel)
      2'b00:   fault_need = CNT_W'(1);
      2'b01:   fault_need = CNT_W'(2);
      2'b10:   fault_need = CNT_W'(4);
      default: fault_need = CNT_W'(FQ_MAX);
    endcase
  endfunction
endpackage

// File: rtl/thermo_cmp.sv
module thermo_cmp #(
  parameter int unsigned TW = thermo_pkg::TEMP_W
) (
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] hi_i,
  input  logic [TW-1:0] lo_i,
  input  logic          ext_i,
  output logic          ge_hi_o,
  output logic          lt_lo_o
);
  localparam int unsigned NW = TW - 1;

  function automatic logic signed [TW-1:0] fit(input logic [TW-1:0] v, input logic ext);
    fit = ext ? $signed(v) : $signed({v[NW-1], v[NW-1:0]});
  endfunction

  logic signed [TW-1:0] t_s, h_s, l_s;
  always_comb begin
    t_s     = fit(temp_i, ext_i);
    h_s     = fit(hi_i, ext_i);
    l_s     = fit(lo_i, ext_i);
    ge_hi_o = (t_s >= h_s);
    lt_lo_o = (t_s < l_s);
  end
endmodule

// File: rtl/thermo_fault_q.sv
module thermo_fault_q #(
  parameter int unsigned CW = thermo_pkg::CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          hit_i,
  input  logic          miss_i,
  input  logic [CW-1:0] need_i,
  output logic          full_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CW'(1);
  assign full_o  = hit_i && !clr_i && (cnt_inc >= need_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || miss_i)    cnt_q <= '0;
    else if (full_o)             cnt_q <= '0;
    else if (hit_i)              cnt_q <= cnt_inc;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(thermo_pkg::FQ_MAX));
endmodule

// File: rtl/thermo_alert.sv
module thermo_alert #(
  parameter int unsigned TW = thermo_pkg::TEMP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          conv_done_i,
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] hi_lim_i,
  input  logic [TW-1:0] lo_lim_i,
  input  logic          ext_mode_i,
  input  logic          int_mode_i,
  input  logic          pol_i,
  input  logic [1:0]    fq_sel_i,
  input  logic          reg_rd_i,
  input  logic          ares_won_i,
  input  logic          shutdown_i,
  output logic          alert_o,
  output logic          status_o,
  output logic          cause_o
);
  import thermo_pkg::*;

  logic ge_hi, lt_lo;
  logic [CNT_W-1:0] need;
  logic [2:0] set_q;
  logic set_chg;
  logic cmp_fault_q, int_act_q, int_lo_q;
  logic cmp_cond, int_cond, int_run;
  logic cmp_full, int_full;
  logic ack;
  logic act;

  thermo_cmp #(.TW(TW)) u_cmp (
    .temp_i (temp_i), .hi_i (hi_lim_i), .lo_i (lo_lim_i), .ext_i (ext_mode_i),
    .ge_hi_o (ge_hi), .lt_lo_o (lt_lo)
  );

  assign need     = fault_need(fq_sel_i);
  assign set_chg  = ({int_mode_i, fq_sel_i} != set_q);
  assign cmp_cond = cmp_fault_q ? lt_lo : ge_hi;
  assign int_cond = int_lo_q ? lt_lo : ge_hi;
  assign int_run  = conv_done_i && int_mode_i && !int_act_q;
  assign ack      = reg_rd_i || ares_won_i || shutdown_i;

  thermo_fault_q #(.CW(CNT_W)) u_cmp_q (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (set_chg),
    .hit_i (conv_done_i && cmp_cond), .miss_i (conv_done_i && !cmp_cond),
    .need_i (need), .full_o (cmp_full)
  );

  thermo_fault_q #(.CW(CNT_W)) u_int_q (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (set_chg || !int_mode_i),
    .hit_i (int_run && int_cond), .miss_i (int_run && !int_cond),
    .need_i (need), .full_o (int_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q       <= 3'b000;
      cmp_fault_q <= 1'b0;
      int_act_q   <= 1'b0;
      int_lo_q    <= 1'b0;
    end else begin
      set_q <= {int_mode_i, fq_sel_i};
      if (cmp_full) cmp_fault_q <= !cmp_fault_q;
      if (!int_mode_i) begin
        int_act_q <= 1'b0;
        int_lo_q  <= 1'b0;
      end else if (int_act_q && ack) begin
        int_act_q <= 1'b0;
        int_lo_q  <= !int_lo_q;
      end else if (int_full) begin
        int_act_q <= 1'b1;
      end
    end
  end

  assign act      = int_mode_i ? int_act_q : cmp_fault_q;
  assign alert_o  = pol_i ? act : !act;
  assign status_o = pol_i ? cmp_fault_q : !cmp_fault_q;
  assign cause_o  = (int_mode_i ? int_lo_q : 1'b0) ^ pol_i;

  // R2 R3
  cmp_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> $stable(cmp_fault_q));
  // R8
  comp_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_mode_i |-> (alert_o == status_o));
  // R5
  int_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_act_q && ack) |=> !int_act_q);
  // R5
  int_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_act_q) |-> $past(conv_done_i));
endmodule

// File: tb/thermo_alert_test.sv
`timescale 1ns/1ps
module thermo_alert_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic conv = 1'b0;
  logic [12:0] temp = '0;
  logic [12:0] hi = 13'h0500;
  logic [12:0] lo = 13'h04B0;
  logic ext = 1'b0, imode = 1'b0, pol = 1'b0;
  logic [1:0] fq = 2'b00;
  logic rd = 1'b0, won = 1'b0, sd = 1'b0;
  logic alert, status, cause;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic  a;
    logic  s;
    logic  c;
    logic  chk_c;
    string tag;
  } exp_t;
  exp_t sb[$];
  exp_t e;

  always #2.5 clk = ~clk;

  thermo_alert uut (
    .clk_i (clk), .rst_ni (rst_ni), .conv_done_i (conv), .temp_i (temp),
    .hi_lim_i (hi), .lo_lim_i (lo), .ext_mode_i (ext), .int_mode_i (imode),
    .pol_i (pol), .fq_sel_i (fq), .reg_rd_i (rd), .ares_won_i (won),
    .shutdown_i (sd), .alert_o (alert), .status_o (status), .cause_o (cause)
  );

  // monitor: one expected item per clock edge following its push
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      n_cmp++;
      if (alert !== e.a || status !== e.s || (e.chk_c && cause !== e.c)) begin
        n_bad++;
        $display("FAIL %s: alert/status/cause got %b%b%b expected %b%b%b",
                 e.tag, alert, status, cause, e.a, e.s, e.chk_c ? e.c : cause);
      end
    end
  end

  task automatic cyc(input logic cv, input logic [12:0] t, input logic r,
                     input logic w, input logic s, input logic ea, input logic es,
                     input logic ec, input logic cc, input string tag);
    exp_t x;
    @(negedge clk);
    conv = cv; temp = t; rd = r; won = w; sd = s;
    x.a = ea; x.s = es; x.c = ec; x.chk_c = cc; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic cv(input logic [12:0] t, input logic ea, input logic es, input string tag);
    cyc(1'b1, t, 1'b0, 1'b0, 1'b0, ea, es, 1'b0, 1'b0, tag);
  endtask

  task automatic quiet;
    @(negedge clk);
    conv = 1'b0; rd = 1'b0; won = 1'b0; sd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 1, "R12 reset idle");

    quiet(); fq = 2'b01;
    cv(13'h0500, 1, 1, "R2 first hot of two");
    cv(13'h0510, 0, 0, "R2 R1 second hot activates");
    cv(13'h04B0, 0, 0, "R3 equal to low holds");
    cv(13'h04A0, 0, 0, "R3 first low of two");
    cv(13'h0100, 1, 1, "R3 second low clears");

    cv(13'h0600, 1, 1, "R4 hot 1");
    cv(13'h0400, 1, 1, "R4 miss restarts");
    cv(13'h0600, 1, 1, "R4 hot again 1");
    cv(13'h0600, 0, 0, "R4 hot again 2");
    cv(13'h0100, 0, 0, "R3 low 1");
    cv(13'h0100, 1, 1, "R3 low 2");

    quiet(); fq = 2'b10;
    for (int i = 0; i < 3; i++) cv(13'h0600, 1, 1, "R1 four: early");
    cv(13'h0600, 0, 0, "R1 four: fourth");
    quiet(); fq = 2'b11;
    for (int i = 0; i < 5; i++) cv(13'h0000, 0, 0, "R1 six: early");
    cv(13'h0000, 1, 1, "R1 six: sixth");
    quiet(); fq = 2'b00;
    cv(13'h0600, 0, 0, "R1 one hot");
    cv(13'h0000, 1, 1, "R1 one low");

    quiet(); fq = 2'b01;
    cv(13'h0600, 1, 1, "R11 hot before change");
    quiet(); fq = 2'b10;
    quiet(); fq = 2'b01;
    cv(13'h0600, 1, 1, "R11 counter was emptied");
    cv(13'h0600, 0, 0, "R11 second after change");
    cv(13'h0000, 0, 0, "R3 low 1");
    cv(13'h0000, 1, 1, "R3 low 2");

    quiet(); pol = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, "R7 R8 R9 inactive pol1");

    quiet(); pol = 1'b0; imode = 1'b1; fq = 2'b00;
    cyc(1, 13'h0500, 0, 0, 0, 0, 0, 0, 1, "R5 R9 interrupt high latch");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R5 latch holds");
    cyc(0, 0, 1, 0, 0, 1, 0, 1, 0, "R5 R8 read clears");
    cyc(1, 13'h0500, 0, 0, 0, 1, 0, 0, 0, "R6 now watching low");
    cyc(1, 13'h04A0, 0, 0, 0, 0, 1, 1, 1, "R6 R9 low latch");
    cyc(0, 0, 0, 1, 0, 1, 1, 0, 0, "R5 won clears");
    cyc(1, 13'h04A0, 0, 0, 0, 1, 1, 0, 0, "R6 rearmed high");
    cyc(1, 13'h0500, 0, 0, 0, 0, 0, 0, 1, "R6 R9 high latch again");
    cyc(0, 0, 0, 0, 1, 1, 0, 0, 0, "R5 shutdown clears");

    quiet(); imode = 1'b0; hi = 13'h0960;
    cv(13'h0000, 1, 1, "R10 low clears");
    cv(13'h0100, 0, 0, "R10 12-bit limit negative");
    cv(13'h0000, 1, 1, "R10 back low");
    quiet(); ext = 1'b1;
    cv(13'h0100, 1, 1, "R10 13-bit limit positive");
    cv(13'h0980, 0, 0, "R10 above 150 C");
    cv(13'h1E70, 1, 1, "R10 negative 13-bit result");

    quiet(); ext = 1'b0; hi = 13'h0500; imode = 1'b1; pol = 1'b1;
    cyc(1, 13'h0500, 0, 0, 0, 1, 1, 1, 1, "R7 R9 pol1 high latch");
    cyc(0, 0, 1, 0, 0, 0, 1, 0, 0, "R7 pol1 read clears");
    cyc(1, 13'h0000, 0, 0, 0, 1, 0, 0, 1, "R9 pol1 low latch");

    quiet();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule